// File: doc/BRIEF.md
# LIN serial port status and break detector

This block sits next to the receive and transmit shift engines of a serial port that can run the LIN protocol. It does not move data itself. It watches the receive line and the handshake strobes of the two engines, and it keeps an 8-bit status word. Software reads this word, and the port's interrupt logic uses it. Reads clear the event flags, and a set condition always has priority over a clearing read, so no event is lost.

The block measures how long the bus stays low, counted in bit-time ticks. The number of low bit times that counts as a break depends on the LIN state: sleeping, slave waiting for a break, or slave active. The block also compares each byte it transmits with the byte that comes back from the bus, and it flags receive, framing, overrun and autobaud conditions.

Top module: `lin_uart_status`

## Requirements
- R1: The status word `stat_word` has these bits: bit 7 receive data available, bit 6 physical layer error, bit 5 overrun/autobaud error, bit 4 framing error, bit 3 break detect, bit 2 transmit data register empty, bit 1 transmitter empty, bit 0 autobaud complete. After reset its value is 8'h06.
- R2: `lin_state` is encoded as 0 = sleep, 1 = slave waiting for break, 2 = slave active, 3 = break detection off. Break detect (bit 3) is set on the `bit_tick` in which `rx_line` has been low for a full count of 4 (sleep), 11 (waiting) or 10 (active) bit times.
- R3: Any cycle in which `rx_line` is high restarts the low-time count. The count saturates at 11 instead of wrapping, so one low period produces at most one break event.
- R4: A break found in the sleep state also pulses `wake_evt` high for one cycle, in the same cycle that bit 3 goes high.
- R5: The block keeps the byte taken by the transmitter on `tx_load`. If the next `rx_done` carries a different `rx_data`, bit 6 is set.
- R6: `rx_done` sets bit 7. `rx_done` with `rx_stop` low also sets bit 4.
- R7: Bit 5 is set by `rx_done` while bit 7 is already 1 and `rd_data` is low. It is also set by `ab_ovf`, which additionally sets bit 0. `ab_done` sets bit 0.
- R8: `rd_data` clears bits 7, 6, 5, 4 and 3. `rd_stat` clears bits 6, 3 and 0 and leaves the other bits unchanged.
- R9: When a set condition and a clearing read of the same bit occur in one cycle, the bit ends up 1.
- R10: `tx_wr` clears bit 2 and `tx_load` sets it; if both occur in one cycle, `tx_wr` wins. `tx_load` clears bit 1 and `tx_done` sets it; if both occur in one cycle, `tx_load` wins.
- R11: `irq_ab` is high one cycle after a cycle in which bit 0 was 1 and `ab_ien` was high. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lin_state | input | 2 | LIN state (encoding in R2) |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| rx_line | input | 1 | Synchronised receive line |
| rx_done | input | 1 | Receiver finished a character |
| rx_data | input | DW | Received character |
| rx_stop | input | 1 | Sampled stop bit of that character |
| tx_wr | input | 1 | Transmit data register written |
| tx_load | input | 1 | Shift register took the transmit byte |
| tx_data | input | DW | Byte taken on tx_load |
| tx_done | input | 1 | Transmitter finished its character |
| ab_done | input | 1 | Autobaud character measured |
| ab_ovf | input | 1 | Autobaud counter overflowed |
| ab_ien | input | 1 | Autobaud interrupt enable |
| rd_stat | input | 1 | Status word read strobe |
| rd_data | input | 1 | Receive data register read strobe |
| stat_word | output | 8 | Status flags (R1) |
| irq_ab | output | 1 | Autobaud interrupt request |
| wake_evt | output | 1 | Wake-up pulse |

## Verification
The bench builds the block with its default values: 8-bit characters and thresholds of 4, 11 and 10 bit times. These values make the saturating counter only four bits wide, so random low runs of a few dozen cycles reach every threshold and drive the counter into saturation. Random low runs on the line are mixed with random strobes that often collide in one cycle, so the set-over-clear priority and the two priority choices for the transmitter bits are exercised many times. Directed sequences hold the line low well past saturation, and they also separate the two read strobes.

// File: rtl/lin_stat_pkg.sv
package lin_stat_pkg;
  typedef enum logic [1:0] {
    LS_SLEEP   = 2'd0,
    LS_WAITBRK = 2'd1,
    LS_ACTIVE  = 2'd2,
    LS_OFF     = 2'd3
  } lin_state_e;

  localparam int SW        = 8;
  localparam int B_RDA     = 7;
  localparam int B_PHYERR  = 6;
  localparam int B_OVR     = 5;
  localparam int B_FRM     = 4;
  localparam int B_BRK     = 3;
  localparam int B_TDEMPTY = 2;
  localparam int B_TXIDLE  = 1;
  localparam int B_ABDONE  = 0;

  localparam logic [SW-1:0] STAT_RST   = 8'h06;
  // 1 = set has priority, 0 = clear has priority
  localparam logic [SW-1:0] STAT_SETW  = 8'b1111_1001;
endpackage

// File: rtl/lin_flag_cell.sv
module lin_flag_cell #(
  parameter logic RST_VAL  = 1'b0,
  parameter logic SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  generate
    if (SET_WINS) begin : g_setw
      always_ff @(posedge clk) begin
        if (rst)        q <= RST_VAL;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
      end
    end else begin : g_clrw
      always_ff @(posedge clk) begin
        if (rst)        q <= RST_VAL;
        else if (clr_i) q <= 1'b0;
        else if (set_i) q <= 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/lin_low_timer.sv
module lin_low_timer
  import lin_stat_pkg::*;
#(
  parameter int TH_SLEEP = 4,
  parameter int TH_WAIT  = 11,
  parameter int TH_ACT   = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  lin_state_e state,
  input  logic       bit_tick,
  input  logic       rx_line,
  output logic       brk_hit,
  output logic       wake_hit
);
  localparam int SAT_I = (TH_WAIT > TH_ACT)
                         ? ((TH_WAIT > TH_SLEEP) ? TH_WAIT : TH_SLEEP)
                         : ((TH_ACT > TH_SLEEP) ? TH_ACT : TH_SLEEP);
  localparam int CW = $clog2(SAT_I + 1);
  localparam logic [CW-1:0] SAT  = CW'(SAT_I);
  localparam logic [CW-1:0] T_SL = CW'(TH_SLEEP);
  localparam logic [CW-1:0] T_WB = CW'(TH_WAIT);
  localparam logic [CW-1:0] T_AC = CW'(TH_ACT);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_inc;
  logic [CW-1:0] thr;
  logic          step;

  always_comb begin
    unique case (state)
      LS_SLEEP:   thr = T_SL;
      LS_WAITBRK: thr = T_WB;
      LS_ACTIVE:  thr = T_AC;
      default:    thr = '0;
    endcase
  end

  assign step    = bit_tick && !rx_line && (cnt != SAT);
  assign cnt_inc = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (rx_line) cnt <= '0;
    else if (step)    cnt <= cnt_inc;
  end

  assign brk_hit  = step && (state != LS_OFF) && (cnt_inc == thr);
  assign wake_hit = brk_hit && (state == LS_SLEEP);
endmodule

// File: rtl/lin_echo_chk.sv
module lin_echo_chk #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_load,
  input  logic [DW-1:0] tx_data,
  input  logic          rx_done,
  input  logic [DW-1:0] rx_data,
  output logic          mismatch
);
  logic [DW-1:0] sent_q;
  logic          pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sent_q <= '0;
      pend_q <= 1'b0;
    end else if (tx_load) begin
      sent_q <= tx_data;
      pend_q <= 1'b1;
    end else if (rx_done) begin
      pend_q <= 1'b0;
    end
  end

  assign mismatch = rx_done && pend_q && (rx_data != sent_q);
endmodule

// File: rtl/lin_uart_status.sv
module lin_uart_status
  import lin_stat_pkg::*;
#(
  parameter int DW       = 8,
  parameter int TH_SLEEP = 4,
  parameter int TH_WAIT  = 11,
  parameter int TH_ACT   = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    lin_state,
  input  logic          bit_tick,
  input  logic          rx_line,
  input  logic          rx_done,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_stop,
  input  logic          tx_wr,
  input  logic          tx_load,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_done,
  input  logic          ab_done,
  input  logic          ab_ovf,
  input  logic          ab_ien,
  input  logic          rd_stat,
  input  logic          rd_data,
  output logic [7:0]    stat_word,
  output logic          irq_ab,
  output logic          wake_evt
);
  logic          brk_hit, wake_hit, echo_bad;
  logic [SW-1:0] flag_q, flag_set, flag_clr;

  lin_low_timer #(.TH_SLEEP(TH_SLEEP), .TH_WAIT(TH_WAIT), .TH_ACT(TH_ACT)) u_low (
    .clk(clk), .rst(rst), .state(lin_state_e'(lin_state)),
    .bit_tick(bit_tick), .rx_line(rx_line),
    .brk_hit(brk_hit), .wake_hit(wake_hit)
  );

  lin_echo_chk #(.DW(DW)) u_echo (
    .clk(clk), .rst(rst), .tx_load(tx_load), .tx_data(tx_data),
    .rx_done(rx_done), .rx_data(rx_data), .mismatch(echo_bad)
  );

  always_comb begin
    flag_set = '0;
    flag_clr = '0;
    flag_set[B_RDA]     = rx_done;
    flag_set[B_PHYERR]  = echo_bad;
    flag_set[B_OVR]     = (rx_done && flag_q[B_RDA] && !rd_data) || ab_ovf;
    flag_set[B_FRM]     = rx_done && !rx_stop;
    flag_set[B_BRK]     = brk_hit;
    flag_set[B_TDEMPTY] = tx_load;
    flag_set[B_TXIDLE]  = tx_done;
    flag_set[B_ABDONE]  = ab_done || ab_ovf;
    flag_clr[B_RDA]     = rd_data;
    flag_clr[B_PHYERR]  = rd_data || rd_stat;
    flag_clr[B_OVR]     = rd_data;
    flag_clr[B_FRM]     = rd_data;
    flag_clr[B_BRK]     = rd_data || rd_stat;
    flag_clr[B_TDEMPTY] = tx_wr;
    flag_clr[B_TXIDLE]  = tx_load;
    flag_clr[B_ABDONE]  = rd_stat;
  end

  for (genvar i = 0; i < SW; i++) begin : g_flag
    lin_flag_cell #(.RST_VAL(STAT_RST[i]), .SET_WINS(STAT_SETW[i])) u_cell (
      .clk(clk), .rst(rst), .set_i(flag_set[i]), .clr_i(flag_clr[i]), .q(flag_q[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_ab   <= 1'b0;
      wake_evt <= 1'b0;
    end else begin
      irq_ab   <= flag_q[B_ABDONE] && ab_ien;
      wake_evt <= wake_hit;
    end
  end

  assign stat_word = flag_q;
endmodule

// File: rtl/lin_uart_status_chk.sv
module lin_uart_status_chk (
  input logic       clk,
  input logic       rst,
  input logic       rx_line,
  input logic       rx_done,
  input logic       rx_stop,
  input logic       rd_data,
  input logic       rd_stat,
  input logic       tx_wr,
  input logic       ab_ovf,
  input logic [7:0] stat_word,
  input logic       wake_evt
);
  assert_reset_value_R1: assert property (@(posedge clk) rst |=> stat_word == 8'h06);

  assert_break_needs_low_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_word[3]) |-> !$past(rx_line));

  assert_wake_with_break_R4: assert property (@(posedge clk) disable iff (rst)
    wake_evt |-> stat_word[3]);

  assert_framing_set_R6: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !rx_stop) |=> stat_word[4]);

  assert_autobaud_ovf_R7: assert property (@(posedge clk) disable iff (rst)
    ab_ovf |=> (stat_word[5] && stat_word[0]));

  assert_set_beats_read_R9: assert property (@(posedge clk) disable iff (rst)
    (rx_done && rd_data) |=> stat_word[7]);

  assert_stat_read_keeps_rx_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && !rd_data && stat_word[7]) |=> stat_word[7]);

  assert_txwr_clears_R10: assert property (@(posedge clk) disable iff (rst)
    tx_wr |=> !stat_word[2]);
endmodule

bind lin_uart_status lin_uart_status_chk u_chk (
  .clk(clk), .rst(rst), .rx_line(rx_line), .rx_done(rx_done), .rx_stop(rx_stop),
  .rd_data(rd_data), .rd_stat(rd_stat), .tx_wr(tx_wr), .ab_ovf(ab_ovf),
  .stat_word(stat_word), .wake_evt(wake_evt)
);

// File: tb/tb_lin_uart_status.sv
`timescale 1ns/1ps
module tb_lin_uart_status;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] lin_state = 2'd0;
  logic       bit_tick = 0, rx_line = 1, rx_done = 0, rx_stop = 1;
  logic [7:0] rx_data = 0, tx_data = 0;
  logic       tx_wr = 0, tx_load = 0, tx_done = 0, ab_done = 0, ab_ovf = 0;
  logic       ab_ien = 0, rd_stat = 0, rd_data = 0;
  logic [7:0] stat_word;
  logic       irq_ab, wake_evt;

  always #2.5 clk = ~clk;

  lin_uart_status dut (
    .clk(clk), .rst(rst), .lin_state(lin_state), .bit_tick(bit_tick), .rx_line(rx_line),
    .rx_done(rx_done), .rx_data(rx_data), .rx_stop(rx_stop), .tx_wr(tx_wr),
    .tx_load(tx_load), .tx_data(tx_data), .tx_done(tx_done), .ab_done(ab_done),
    .ab_ovf(ab_ovf), .ab_ien(ab_ien), .rd_stat(rd_stat), .rd_data(rd_data),
    .stat_word(stat_word), .irq_ab(irq_ab), .wake_evt(wake_evt)
  );

  int n_chk = 0, n_bad = 0;
  bit model_on = 0;

  // reference state derived from the requirements
  logic [7:0] m_stat = 8'h06;
  logic       m_irq = 0, m_wake = 0, m_pend = 0;
  logic [7:0] m_sent = 0;
  int         m_low = 0;

  function automatic int thr_of(input logic [1:0] s);
    case (s)
      2'd0: return 4;
      2'd1: return 11;
      2'd2: return 10;
      default: return -1;
    endcase
  endfunction

  function automatic string tag_of(input int b);
    case (b)
      7: return "R6"; 6: return "R5"; 5: return "R7"; 4: return "R6";
      3: return "R2"; 2: return "R10"; 1: return "R10"; default: return "R7";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_stat = 8'h06; m_irq = 0; m_wake = 0; m_pend = 0; m_low = 0;
    end else begin
      logic [7:0] s, c, n;
      logic brk;
      brk = 0;
      if (rx_line) m_low = 0;
      else if (bit_tick && m_low < 11) begin
        m_low++;
        if (m_low == thr_of(lin_state)) brk = 1;
      end
      m_irq = m_stat[0] && ab_ien;
      s = 0; c = 0;
      s[7] = rx_done;
      s[6] = rx_done && m_pend && (rx_data != m_sent);
      s[5] = (rx_done && m_stat[7] && !rd_data) || ab_ovf;
      s[4] = rx_done && !rx_stop;
      s[3] = brk;
      s[0] = ab_done || ab_ovf;
      c[7] = rd_data; c[6] = rd_data || rd_stat; c[5] = rd_data;
      c[4] = rd_data; c[3] = rd_data || rd_stat; c[0] = rd_stat;
      n = (m_stat & ~c) | s;
      n[2] = tx_wr ? 1'b0 : (tx_load ? 1'b1 : m_stat[2]);
      n[1] = tx_load ? 1'b0 : (tx_done ? 1'b1 : m_stat[1]);
      m_stat = n;
      m_wake = brk && (lin_state == 2'd0);
      if (tx_load) begin m_sent = tx_data; m_pend = 1; end
      else if (rx_done) m_pend = 0;
    end
  end

  always @(negedge clk) begin
    if (model_on && !rst) begin
      n_chk++;
      if (stat_word !== m_stat || irq_ab !== m_irq || wake_evt !== m_wake) begin
        n_bad++;
        for (int b = 0; b < 8; b++)
          if (stat_word[b] !== m_stat[b])
            $display("FAIL %s status bit %0d: got %b expected %b", tag_of(b), b, stat_word[b], m_stat[b]);
        if (irq_ab !== m_irq)
          $display("FAIL R11 irq_ab: got %b expected %b", irq_ab, m_irq);
        if (wake_evt !== m_wake)
          $display("FAIL R4 wake_evt: got %b expected %b", wake_evt, m_wake);
      end
    end
  end

  task automatic expect_bit(input string tag, input logic got, input logic exp, input string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b", tag, what, got, exp);
    end
  endtask

  task automatic idle();
    bit_tick = 0; rx_done = 0; tx_wr = 0; tx_load = 0; tx_done = 0;
    ab_done = 0; ab_ovf = 0; rd_stat = 0; rd_data = 0; rx_stop = 1;
  endtask

  task automatic ticks_low(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); idle(); rx_line = 0; bit_tick = 1;
      @(negedge clk); idle();
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    n_chk++;
    if (stat_word !== 8'h06) begin
      n_bad++;
      $display("FAIL R1 reset value: got %h expected 06", stat_word);
    end
    model_on = 1;

    // R2: sleep threshold 4 plus R4 wake pulse
    lin_state = 2'd0;
    ticks_low(3);
    expect_bit("R2", stat_word[3], 1'b0, "no break after 3 low bits");
    @(negedge clk); rx_line = 0; bit_tick = 1;
    @(negedge clk); idle();
    expect_bit("R2", stat_word[3], 1'b1, "break after 4 low bits asleep");
    rx_line = 1;
    @(negedge clk); rd_stat = 1; @(negedge clk); idle();
    expect_bit("R8", stat_word[3], 1'b0, "status read clears break");

    // R3: long low in active state -> one event only
    lin_state = 2'd2;
    ticks_low(10);
    expect_bit("R2", stat_word[3], 1'b1, "break at 10 bits active");
    @(negedge clk); rd_stat = 1; @(negedge clk); idle();
    ticks_low(25);
    expect_bit("R3", stat_word[3], 1'b0, "saturated count gives no second break");
    rx_line = 1; @(negedge clk);
    lin_state = 2'd1;
    ticks_low(10);
    expect_bit("R2", stat_word[3], 1'b0, "waiting state needs 11 bits");
    ticks_low(1);
    expect_bit("R2", stat_word[3], 1'b1, "break at 11 bits waiting");
    rx_line = 1;

    // R8 / R9 directed
    @(negedge clk); rd_data = 1; @(negedge clk); idle();
    rx_done = 1; rx_stop = 0; @(negedge clk); idle();
    rd_stat = 1; @(negedge clk); idle();
    expect_bit("R8", stat_word[4], 1'b1, "status read keeps framing error");
    rd_data = 1; @(negedge clk); idle();
    expect_bit("R8", stat_word[4], 1'b0, "data read clears framing error");
    rx_done = 1; rd_data = 1; @(negedge clk); idle();
    expect_bit("R9", stat_word[7], 1'b1, "set wins over data read");
    expect_bit("R9", stat_word[5], 1'b0, "no overrun on read-and-receive");

    // R5 echo
    tx_load = 1; tx_data = 8'hA5; @(negedge clk); idle();
    rx_done = 1; rx_data = 8'hA4; @(negedge clk); idle();
    expect_bit("R5", stat_word[6], 1'b1, "echo mismatch");

    // R10 collisions
    tx_wr = 1; tx_load = 1; tx_done = 1; @(negedge clk); idle();
    expect_bit("R10", stat_word[2], 1'b0, "write beats load");
    expect_bit("R10", stat_word[1], 1'b0, "load beats done");

    // R11
    ab_ien = 1; ab_done = 1; @(negedge clk); idle();
    @(negedge clk);
    expect_bit("R11", irq_ab, 1'b1, "autobaud interrupt");
    ab_ien = 0; @(negedge clk); @(negedge clk);
    expect_bit("R11", irq_ab, 1'b0, "interrupt masked");

    // random phase
    for (int cyc = 0; cyc < 40000; cyc++) begin
      @(negedge clk);
      idle();
      bit_tick = ($urandom_range(3) == 0);
      if ($urandom_range(59) == 0) rx_line = ~rx_line;
      rx_done = ($urandom_range(15) == 0);
      rx_stop = ($urandom_range(7) != 0);
      rx_data = ($urandom_range(1) == 0) ? tx_data : 8'($urandom);
      tx_wr   = ($urandom_range(19) == 0);
      tx_load = ($urandom_range(19) == 0);
      if (tx_load) tx_data = 8'($urandom);
      tx_done = ($urandom_range(19) == 0);
      ab_done = ($urandom_range(63) == 0);
      ab_ovf  = ($urandom_range(63) == 0);
      rd_stat = ($urandom_range(9) == 0);
      rd_data = ($urandom_range(9) == 0);
      if ($urandom_range(199) == 0) lin_state = 2'($urandom);
      if ($urandom_range(99) == 0) ab_ien = ~ab_ien;
    end
    @(negedge clk); idle();
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule